// File: doc/BRIEF.md
# Push-Button Parameter Entry Controller

This block lets an operator set three camera parameters from four push-buttons and a four-digit seven-segment display. The parameters are gain mode, acquisition frame rate and exposure time. One key steps through the parameters. Two keys step the value shown up or down within that parameter's own limits. A fourth key confirms the value. Only a confirmed value is stored as the committed setting, and only a confirmed value is sent to the host controller as a four-byte command on an asynchronous serial line.

The raw key inputs are synchronised and debounced inside the block. The display is scanned one digit at a time with active-low digit enables. It shows the edited value as four hexadecimal digits. The decimal point marks which parameter is selected. The serial line uses 8N1 framing at a baud divisor set by a parameter.

Top module: `param_entry_panel`

## Requirements
- R1: A key level counts only after the synchronised input has differed from the accepted level for DEB_CYCLES consecutive clocks. A shorter pulse has no effect. A press acts exactly once, on the accepted rising edge, however long the key is held. Key bits are keyRaw[0]=mode, [1]=up, [2]=down, [3]=confirm, and a key reads 1 when pressed.
- R2: The mode key cycles the selection gain (index 0) → frame rate (1) → exposure (2) → gain. The decimal point (segOut[7]) is lit only while digit k is enabled, where k is the selected index.
- R3: The limits, in decimal, are: gain 0..3 with step 1 and reset value 0; frame rate 10..200 with step 10 and reset value 100; exposure 5..9995 with step 5 and reset value 1000. The edited value never leaves the limits of the selected parameter.
- R4: The up key adds the step and the down key subtracts it. At the maximum, up leaves the value unchanged. At the minimum, down leaves the value unchanged. The value never wraps.
- R5: Exactly one digit enable (digitEnN, active low) is 0 at any time. Each digit is enabled for SCAN_CYCLES clocks, in the order 0,1,2,3. Digit k shows hex nibble k of the edited value, with digit 3 the most significant. The segments are active high, with segOut[0..6] = a..g, and use the usual hexadecimal shapes.
- R6: The confirm key stores the edited value as the committed value of the selected parameter. It then sends the bytes 0xA5, the parameter ID (gain 0x10, rate 0x20, exposure 0x30), the value high byte and the value low byte, in that order.
- R7: Each byte goes out as a low start bit, then eight data bits LSB first, then a high stop bit. Each bit lasts BAUD_DIV clocks. The four bytes follow one another with no gap, and the line is high when idle.
- R8: The mode key throws away any edit that has not been confirmed. The display then shows the last committed value of the newly selected parameter.
- R9: A confirm press made while a command is still being sent is ignored. It neither commits nor sends.
- R10: When presses are accepted in the same clock, only one acts, with priority mode > confirm > up > down.
- R11: After reset the gain parameter is selected, the display shows 0000, and the serial line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| keyRaw | input | 4 | Raw key levels: mode, up, down, confirm (bit 0..3) |
| segOut | output | 8 | Segments a..g (bits 0..6) and decimal point (bit 7), active high |
| digitEnN | output | 4 | Digit enables, active low, one at a time |
| txOut | output | 1 | Asynchronous serial command output, idle high |

## Verification
Some properties are checked on every clock by assertions placed beside the logic:
- the edited value stays within the selected parameter's limits, and holds at a saturated limit;
- committed values change only on a confirm strobe;
- at most one action strobe is active, and no commit is issued while the transmitter is busy;
- exactly one digit is enabled, each press pulse lasts one clock, and the serial line is high when idle and steady within a bit.

Other behaviour only the bench scenarios can show: the rejection of glitches and of held keys, the cycle order of the selection, the discarding of unconfirmed edits, and the byte content and bit timing of a command. Priority between simultaneous keys, and a confirm press dropped during a busy transmission, are also shown only by the bench.

// File: rtl/param_entry_pkg.sv
package param_entry_pkg;
  localparam int VAL_W  = 16;
  localparam int NPARAM = 3;
  localparam int IDX_W  = 2;
  localparam int NKEY   = 4;
  localparam int NDIGIT = 4;
  localparam int NIB_W  = 4;
  localparam int NBYTES = 4;
  localparam int FRAME_W = 8 * NBYTES;
  localparam logic [7:0] SYNC_BYTE = 8'hA5;

  localparam int KEY_MODE = 0;
  localparam int KEY_UP   = 1;
  localparam int KEY_DOWN = 2;
  localparam int KEY_OK   = 3;

  typedef struct packed {
    logic             nextMode;
    logic             incr;
    logic             decr;
    logic             commit;
    logic [IDX_W-1:0] loadIdx;
  } ctrlStrobes_t;

  function automatic logic [VAL_W-1:0] paramMin(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return VAL_W'(10);
      2'd2:    return VAL_W'(5);
      default: return VAL_W'(0);
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] paramMax(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return VAL_W'(200);
      2'd2:    return VAL_W'(9995);
      default: return VAL_W'(3);
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] paramStep(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return VAL_W'(10);
      2'd2:    return VAL_W'(5);
      default: return VAL_W'(1);
    endcase
  endfunction

  function automatic logic [VAL_W-1:0] paramInit(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return VAL_W'(100);
      2'd2:    return VAL_W'(1000);
      default: return VAL_W'(0);
    endcase
  endfunction

  function automatic logic [7:0] paramCode(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd1:    return 8'h20;
      2'd2:    return 8'h30;
      default: return 8'h10;
    endcase
  endfunction

  function automatic logic [6:0] hexSeg(input logic [NIB_W-1:0] nib);
    case (nib)
      4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
      4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
      4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
      4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/param_entry_debounce.sv
module param_entry_debounce #(
  parameter int DEB_CYCLES = 500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyIn,
  output logic pressPulse
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic [1:0]       syncQ;
  logic             stableQ;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ      <= '0;
      stableQ    <= 1'b0;
      holdCnt    <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncQ      <= {syncQ[0], keyIn};
      pressPulse <= 1'b0;
      if (syncQ[1] == stableQ) begin
        holdCnt <= '0;
      end else if (holdCnt == CNT_W'(DEB_CYCLES - 1)) begin
        stableQ    <= syncQ[1];
        holdCnt    <= '0;
        pressPulse <= syncQ[1];
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

  // R1: a press is a single-cycle event
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |=> !pressPulse);

  // R1: the accepted level only moves after the synchronised input disagreed with it
  a_r1_level_follows: assert property (@(posedge clk) disable iff (!rstN)
    (stableQ != $past(stableQ)) |-> (stableQ == $past(syncQ[1])));
endmodule

// File: rtl/param_entry_ctrl.sv
module param_entry_ctrl
  import param_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NKEY-1:0]   press,
  input  logic              txBusy,
  output ctrlStrobes_t      strobes,
  output logic [IDX_W-1:0]  modeIdx
);
  logic [IDX_W-1:0] modeNext;

  always_comb begin
    modeNext = (modeIdx == IDX_W'(NPARAM - 1)) ? '0 : modeIdx + 1'b1;
  end

  always_comb begin
    strobes         = '0;
    strobes.loadIdx = modeNext;
    if (press[KEY_MODE])      strobes.nextMode = 1'b1;
    else if (press[KEY_OK])   strobes.commit   = !txBusy;
    else if (press[KEY_UP])   strobes.incr     = 1'b1;
    else if (press[KEY_DOWN]) strobes.decr     = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 modeIdx <= '0;
    else if (strobes.nextMode) modeIdx <= modeNext;
  end

  // R2: selection index stays among the defined parameters
  a_r2_mode_range: assert property (@(posedge clk) disable iff (!rstN)
    modeIdx < IDX_W'(NPARAM));

  // R10: at most one action per clock
  a_r10_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.nextMode, strobes.incr, strobes.decr, strobes.commit}));

  // R9: nothing is committed while a command is in flight
  a_r9_no_commit_busy: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !strobes.commit);

  // R2: the selection moves only on the mode strobe
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.nextMode |=> $stable(modeIdx));
endmodule

// File: rtl/param_entry_dpath.sv
module param_entry_dpath
  import param_entry_pkg::*;
#(
  parameter int SCAN_CYCLES = 50000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   modeIdx,
  output logic [FRAME_W-1:0] txFrame,
  output logic [7:0]         segOut,
  output logic [NDIGIT-1:0]  digitEnN
);
  localparam int SCAN_W = (SCAN_CYCLES > 1) ? $clog2(SCAN_CYCLES) : 1;
  localparam int DIG_W  = $clog2(NDIGIT);

  logic [VAL_W-1:0]             editVal;
  logic [NPARAM-1:0][VAL_W-1:0] committed;
  logic [VAL_W-1:0]             curMin, curMax, curStep, stepUp, stepDown;
  logic [SCAN_W-1:0]            scanCnt;
  logic [DIG_W-1:0]             digitIdx;
  logic [NIB_W-1:0]             shownNib;

  always_comb begin
    curMin   = paramMin(modeIdx);
    curMax   = paramMax(modeIdx);
    curStep  = paramStep(modeIdx);
    stepUp   = (editVal > curMax - curStep) ? curMax : editVal + curStep;
    stepDown = (editVal < curMin + curStep) ? curMin : editVal - curStep;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      editVal <= paramInit('0);
      for (int i = 0; i < NPARAM; i++) committed[i] <= paramInit(IDX_W'(i));
    end else begin
      if (strobes.nextMode)  editVal <= committed[strobes.loadIdx];
      else if (strobes.incr) editVal <= stepUp;
      else if (strobes.decr) editVal <= stepDown;
      if (strobes.commit) committed[modeIdx] <= editVal;
    end
  end

  assign txFrame = {SYNC_BYTE, paramCode(modeIdx), editVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanCnt  <= '0;
      digitIdx <= '0;
    end else if (scanCnt == SCAN_W'(SCAN_CYCLES - 1)) begin
      scanCnt  <= '0;
      digitIdx <= digitIdx + 1'b1;
    end else begin
      scanCnt <= scanCnt + 1'b1;
    end
  end

  always_comb begin
    shownNib = editVal[{digitIdx, 2'b00} +: NIB_W];
    segOut   = {(IDX_W'(digitIdx) == modeIdx), hexSeg(shownNib)};
    digitEnN = ~(NDIGIT'(1) << digitIdx);
  end

  // R3: edited value inside the selected parameter's limits
  a_r3_in_limits: assert property (@(posedge clk) disable iff (!rstN)
    (editVal >= paramMin(modeIdx)) && (editVal <= paramMax(modeIdx)));

  // R4: no wrap at the top
  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incr && editVal == curMax) |=> (editVal == $past(editVal)));

  // R4: no wrap at the bottom
  a_r4_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.decr && editVal == curMin) |=> (editVal == $past(editVal)));

  // R6: committed values move only on a confirm strobe
  a_r6_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commit |=> $stable(committed));

  // R5: exactly one digit enabled
  a_r5_one_digit: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~digitEnN) == 1);
endmodule

// File: rtl/param_entry_uart.sv
module param_entry_uart
  import param_entry_pkg::*;
#(
  parameter int BAUD_DIV = 434
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               txBusy,
  output logic               txOut
);
  localparam int BAUD_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam int BIDX_W = $clog2(NBYTES);

  logic [BAUD_W-1:0]  baudCnt;
  logic [3:0]         bitIdx;
  logic [BIDX_W-1:0]  byteIdx;
  logic [9:0]         shiftQ;
  logic [FRAME_W-1:0] frameBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      baudCnt  <= '0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      shiftQ   <= '1;
      frameBuf <= '0;
    end else if (!txBusy) begin
      if (start) begin
        txBusy   <= 1'b1;
        frameBuf <= frame;
        shiftQ   <= {1'b1, frame[FRAME_W-1 -: 8], 1'b0};
        baudCnt  <= '0;
        bitIdx   <= '0;
        byteIdx  <= '0;
      end
    end else if (baudCnt == BAUD_W'(BAUD_DIV - 1)) begin
      baudCnt <= '0;
      if (bitIdx == 4'd9) begin
        if (byteIdx == BIDX_W'(NBYTES - 1)) begin
          txBusy <= 1'b0;
          shiftQ <= '1;
        end else begin
          byteIdx  <= byteIdx + 1'b1;
          bitIdx   <= '0;
          frameBuf <= frameBuf << 8;
          shiftQ   <= {1'b1, frameBuf[FRAME_W-9 -: 8], 1'b0};
        end
      end else begin
        bitIdx <= bitIdx + 1'b1;
        shiftQ <= {1'b1, shiftQ[9:1]};
      end
    end else begin
      baudCnt <= baudCnt + 1'b1;
    end
  end

  assign txOut = txBusy ? shiftQ[0] : 1'b1;

  // R7: line idles high
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txOut);

  // R7: a bit holds its level for the whole bit time
  a_r7_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && baudCnt != '0) |-> $stable(txOut));
endmodule

// File: rtl/param_entry_panel.sv
module param_entry_panel
  import param_entry_pkg::*;
#(
  parameter int DEB_CYCLES  = 500000,
  parameter int SCAN_CYCLES = 50000,
  parameter int BAUD_DIV    = 434
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  keyRaw,
  output logic [7:0]  segOut,
  output logic [3:0]  digitEnN,
  output logic        txOut
);
  logic [NKEY-1:0]    press;
  ctrlStrobes_t       strobes;
  logic [IDX_W-1:0]   modeIdx;
  logic               txBusy;
  logic [FRAME_W-1:0] txFrame;

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    param_entry_debounce #(.DEB_CYCLES(DEB_CYCLES)) i_deb (
      .clk(clk), .rstN(rstN), .keyIn(keyRaw[k]), .pressPulse(press[k]));
  end

  param_entry_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .press(press), .txBusy(txBusy),
    .strobes(strobes), .modeIdx(modeIdx));

  param_entry_dpath #(.SCAN_CYCLES(SCAN_CYCLES)) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .modeIdx(modeIdx),
    .txFrame(txFrame), .segOut(segOut), .digitEnN(digitEnN));

  param_entry_uart #(.BAUD_DIV(BAUD_DIV)) i_uart (
    .clk(clk), .rstN(rstN), .start(strobes.commit), .frame(txFrame),
    .txBusy(txBusy), .txOut(txOut));
endmodule

// File: tb/test_param_entry_panel.sv
module test_param_entry_panel;
  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 8;
  localparam int SCAN = 4;
  localparam int BAUD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] keyRaw = '0;
  logic [7:0] segOut;
  logic [3:0] digitEnN;
  logic       txOut;

  int vectors = 0;
  int miscompares = 0;

  int          mMode;
  int unsigned mEdit;
  int unsigned mComm [3];

  param_entry_panel #(.DEB_CYCLES(DEB), .SCAN_CYCLES(SCAN), .BAUD_DIV(BAUD)) i_param_entry_panel (
    .clk(clk), .rstN(rstN), .keyRaw(keyRaw), .segOut(segOut), .digitEnN(digitEnN), .txOut(txOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned bMin(int m);
    return (m == 1) ? 10 : (m == 2) ? 5 : 0;
  endfunction
  function automatic int unsigned bMax(int m);
    return (m == 1) ? 200 : (m == 2) ? 9995 : 3;
  endfunction
  function automatic int unsigned bStep(int m);
    return (m == 1) ? 10 : (m == 2) ? 5 : 1;
  endfunction
  function automatic int unsigned bInit(int m);
    return (m == 1) ? 100 : (m == 2) ? 1000 : 0;
  endfunction
  function automatic int unsigned bId(int m);
    return (m == 1) ? 32'h20 : (m == 2) ? 32'h30 : 32'h10;
  endfunction
  function automatic logic [6:0] bSeg(logic [3:0] n);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  task automatic check(string req, int unsigned act, int unsigned exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic checkDisplay(string req, int unsigned val, int mode);
    logic [15:0] v = 16'(val);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] expSeg;
      while (digitEnN !== ~(4'b0001 << k)) @(negedge clk);
      expSeg = {(k == mode), bSeg(v[k*4 +: 4])};
      check({req, " display"}, segOut, expSeg);
    end
  endtask

  task automatic holdKeys(logic [3:0] mask, int hi);
    @(negedge clk);
    keyRaw = mask;
    repeat (hi) @(negedge clk);
    keyRaw = '0;
    repeat (DEB + 4) @(negedge clk);
  endtask

  task automatic rxFrame(string req, int unsigned b0, int unsigned b1, int unsigned b2, int unsigned b3);
    int unsigned expB [4] = '{b0, b1, b2, b3};
    for (int b = 0; b < 4; b++) begin
      logic [7:0] data;
      while (txOut !== 1'b0) @(negedge clk);
      repeat (BAUD/2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (BAUD) @(negedge clk);
        data[i] = txOut;
      end
      repeat (BAUD) @(negedge clk);
      check({req, " stop bit"}, txOut, 1);
      check({req, " byte"}, data, expB[b]);
    end
    repeat (BAUD) @(negedge clk);
  endtask

  // apply one key to the model and the design, then check
  task automatic doKey(int k, string req);
    if (k == 0) begin
      mMode = (mMode + 1) % 3;
      mEdit = mComm[mMode];
      holdKeys(4'b0001, DEB + 4);
    end else if (k == 3) begin
      mComm[mMode] = mEdit;
      fork
        holdKeys(4'b1000, DEB + 4);
        rxFrame(req, 32'hA5, bId(mMode), (mEdit >> 8) & 32'hFF, mEdit & 32'hFF);
      join
    end else if (k == 1) begin
      mEdit = (mEdit + bStep(mMode) > bMax(mMode)) ? bMax(mMode) : mEdit + bStep(mMode);
      holdKeys(4'b0010, DEB + 4);
    end else begin
      mEdit = (mEdit < bMin(mMode) + bStep(mMode)) ? bMin(mMode) : mEdit - bStep(mMode);
      holdKeys(4'b0100, DEB + 4);
    end
    checkDisplay(req, mEdit, mMode);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mMode = 0;
    for (int i = 0; i < 3; i++) mComm[i] = bInit(i);
    mEdit = mComm[0];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 line idle", txOut, 1);
    checkDisplay("R11", 0, 0);

    // R5 dwell of one digit
    begin
      int cnt = 0;
      while (digitEnN !== 4'b1110) @(negedge clk);
      while (digitEnN === 4'b1110) begin cnt++; @(negedge clk); end
      check("R5 dwell", cnt, SCAN);
      check("R5 next digit", digitEnN, 4'b1101);
    end

    // R1 short glitch ignored
    holdKeys(4'b0010, DEB / 2);
    checkDisplay("R1 glitch", mEdit, mMode);

    // R1 long hold acts once
    mEdit = 1;
    holdKeys(4'b0010, 4 * DEB);
    checkDisplay("R1 hold once", mEdit, mMode);

    // R4 saturation on gain
    for (int i = 0; i < 4; i++) doKey(1, "R4 up");
    check("R4 gain max", mEdit, 3);
    for (int i = 0; i < 5; i++) doKey(2, "R4 down");
    check("R4 gain min", mEdit, 0);

    // R2, R8 mode cycling and discard
    doKey(0, "R2 to rate");
    doKey(1, "R8 edit rate");
    doKey(0, "R2 to exposure");
    doKey(0, "R2 to gain");
    doKey(0, "R8 rate discarded");
    check("R8 rate shown", mEdit, 100);

    // R6, R7 commit and send, R9 confirm ignored while busy
    mEdit = 110;
    holdKeys(4'b0010, DEB + 4);
    mComm[1] = 110;
    fork
      rxFrame("R6 R7 frame", 32'hA5, 32'h20, 32'h00, 32'h6E);
      begin
        holdKeys(4'b1000, DEB + 4);
        holdKeys(4'b0010, DEB + 4);
        holdKeys(4'b1000, DEB + 4);
      end
    join
    begin
      int lowSeen = 0;
      repeat (20 * BAUD) begin @(negedge clk); if (txOut !== 1'b1) lowSeen++; end
      check("R9 no second frame", lowSeen, 0);
    end
    mEdit = 120;
    checkDisplay("R9 edit kept", mEdit, mMode);
    doKey(0, "R9 to exposure");
    doKey(0, "R9 to gain");
    doKey(0, "R9 rate");
    check("R9 committed unchanged", mEdit, 110);

    // R10 up and down together: up wins
    mEdit = 120;
    holdKeys(4'b0110, DEB + 4);
    checkDisplay("R10 up over down", mEdit, mMode);
    // R10 mode and up together: mode wins
    mMode = 2; mEdit = mComm[2];
    holdKeys(4'b0011, DEB + 4);
    checkDisplay("R10 mode over up", mEdit, mMode);

    // R3 R4 exposure upper limit
    for (int i = 0; i < 1800; i++) begin
      mEdit = (mEdit + 5 > 9995) ? 9995 : mEdit + 5;
      holdKeys(4'b0010, DEB + 4);
    end
    checkDisplay("R3 exposure max", mEdit, mMode);
    check("R3 exposure max value", mEdit, 9995);
    doKey(3, "R6 exposure frame");

    // random mix, R2 R4 R6 R8
    for (int n = 0; n < 40; n++) begin
      int k = int'($urandom_range(0, 3));
      doKey(k, "R2 R4 R6 R8 random");
    end

    summary();
    $finish;
  end
endmodule